// File: doc/BRIEF.md
# Post-Modify Pointer Address Generator

This block serves register-indirect memory and I/O operands. Each request gives it a 16-bit pointer value and a 4-bit step code. The block returns two results. The first is the address for the access, which is always the pointer as it stood before the instruction. The second is the pointer value for the register file to write back once the access is done, together with a write-back enable.

The step code can move the pointer up or down by one to four bytes, or leave it unchanged. Byte moves, word moves and byte I/O transfers all count the step in bytes. A word access can therefore leave the pointer on an odd boundary, for example after a step of three bytes. The pointer arithmetic wraps at 2^16. The register file and the memory port are outside the block. Results are registered and appear one clock after the request.

Top module: `post_mod_agen`

## Requirements
- R1: While reset is asserted and on the first clock after it, `out_valid`, `wb_en`, `addr_out` and `wb_data` are all 0.
- R2: `out_valid` is high in the clock cycle after an edge that sampled `req_valid` high, and low in the cycle after an edge that sampled it low.
- R3: For each accepted request, `addr_out` equals the `ptr_in` of that request, whatever the step code is.
- R4: Step codes 0, 1, 2 and 3 give `wb_data` = pointer + 1, 2, 3 and 4 respectively, with `wb_en` = 1.
- R5: Step codes 4, 5, 6 and 7 give `wb_data` = pointer − 1, 2, 3 and 4 respectively, with `wb_en` = 1.
- R6: Step code 8 and every code from 9 to 15 give `wb_en` = 0 and `wb_data` = pointer.
- R7: Pointer updates wrap modulo 2^16. For example, 0xFFFE with code 3 gives 0x0002, and 0x0001 with code 7 gives 0xFFFD.
- R8: In a cycle where `out_valid` is 0, `wb_en` is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A register-indirect operand is presented this cycle |
| ptr_in | input | 16 | Pointer register value before modification |
| mod_code | input | 4 | Step code: 0-3 up by 1-4, 4-7 down by 1-4, 8-15 no change |
| out_valid | output | 1 | Results for the previous request are valid |
| addr_out | output | 16 | Effective address: the unmodified pointer |
| wb_data | output | 16 | Pointer value to write back |
| wb_en | output | 1 | Write-back enable, high only when the pointer changes |

## Verification
A fault in the step decode shows up at the ports one cycle after the request, in two ways: `wb_data` sits the wrong distance from `addr_out`, or `wb_en` is set for a hold code (or clear for a stepping one). A fault in the carry or borrow path can only be seen near the wrap points, so the stimulus includes pointers close to 0x0000 and 0xFFFF. The output register has no internal state beyond one cycle. A stale or dropped valid is therefore visible on the very next cycle as `out_valid` disagreeing with the previous `req_valid`.

// File: rtl/amg_pkg.sv
package amg_pkg;
    localparam int unsigned PTR_W  = 16;
    localparam int unsigned CODE_W = 4;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

    typedef struct packed {
        logic             valid;
        logic             wen;
        logic [PTR_W-1:0] addr;
        logic [PTR_W-1:0] nxt;
    } agen_out_t;
endpackage

// File: rtl/amg_step_decode.sv
module amg_step_decode
    import amg_pkg::*;
#(
    parameter int unsigned CW       = 4,
    parameter int unsigned MAX_STEP = 4,
    parameter int unsigned MAG_W    = 3
) (
    input  logic [CW-1:0]    code,
    output step_dir_e        dir,
    output logic [MAG_W-1:0] mag
);
    localparam int unsigned UP_LAST   = MAX_STEP - 1;
    localparam int unsigned DOWN_LAST = 2 * MAX_STEP - 1;

    always_comb begin
        dir = STEP_HOLD;
        mag = '0;
        if (32'(code) <= UP_LAST) begin
            dir = STEP_UP;
            mag = MAG_W'(32'(code) + 1);
        end else if (32'(code) <= DOWN_LAST) begin
            dir = STEP_DOWN;
            mag = MAG_W'(32'(code) - MAX_STEP + 1);
        end
    end

    // R4/R5: a stepping code always yields a nonzero magnitude within range
    always_comb begin
        if (dir != STEP_HOLD)
            a_r4_mag_range: assert (mag != '0 && 32'(mag) <= MAX_STEP);
    end
endmodule

// File: rtl/amg_ptr_adder.sv
module amg_ptr_adder
    import amg_pkg::*;
#(
    parameter int unsigned PW        = 16,
    parameter int unsigned MAG_W     = 3,
    parameter bit          TWOS_PATH = 1'b1
) (
    input  logic [PW-1:0]    ptr,
    input  step_dir_e        dir,
    input  logic [MAG_W-1:0] mag,
    output logic [PW-1:0]    nxt
);
    logic [PW-1:0] mag_ext;
    assign mag_ext = PW'(mag);

    generate
        if (TWOS_PATH) begin : g_twos
            logic [PW-1:0] addend;
            always_comb begin
                unique case (dir)
                    STEP_UP:   addend = mag_ext;
                    STEP_DOWN: addend = ~mag_ext + PW'(1);
                    default:   addend = '0;
                endcase
                nxt = ptr + addend;
            end
        end else begin : g_split
            always_comb begin
                unique case (dir)
                    STEP_UP:   nxt = ptr + mag_ext;
                    STEP_DOWN: nxt = ptr - mag_ext;
                    default:   nxt = ptr;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/post_mod_agen.sv
module post_mod_agen
    import amg_pkg::*;
#(
    parameter int unsigned MAX_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic [CODE_W-1:0] mod_code,
    output logic              out_valid,
    output logic [PTR_W-1:0]  addr_out,
    output logic [PTR_W-1:0]  wb_data,
    output logic              wb_en
);
    localparam int unsigned MAG_W = $clog2(MAX_STEP + 1);

    step_dir_e        dir_w;
    logic [MAG_W-1:0] mag_w;
    logic [PTR_W-1:0] nxt_w;
    agen_out_t        st_d, st_q;

    amg_step_decode #(
        .CW(CODE_W), .MAX_STEP(MAX_STEP), .MAG_W(MAG_W)
    ) u_dec (
        .code(mod_code), .dir(dir_w), .mag(mag_w)
    );

    amg_ptr_adder #(
        .PW(PTR_W), .MAG_W(MAG_W), .TWOS_PATH(1'b1)
    ) u_add (
        .ptr(ptr_in), .dir(dir_w), .mag(mag_w), .nxt(nxt_w)
    );

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.valid = 1'b1;
            st_d.addr  = ptr_in;
            st_d.nxt   = nxt_w;
            st_d.wen   = (dir_w != STEP_HOLD);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign addr_out  = st_q.addr;
    assign wb_data   = st_q.nxt;
    assign wb_en     = st_q.wen;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(req_valid)));

    a_r3_addr_is_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid)) |-> (addr_out == $past(ptr_in)));

    a_r6_hold_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wb_en) |-> (wb_data == addr_out));

    a_r7_step_distance: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (((wb_data - addr_out) >= PTR_W'(1) && (wb_data - addr_out) <= PTR_W'(MAX_STEP)) ||
                   ((addr_out - wb_data) >= PTR_W'(1) && (addr_out - wb_data) <= PTR_W'(MAX_STEP))));

    a_r8_wen_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !wb_en);
endmodule

// File: tb/sim_post_mod_agen.sv
module sim_post_mod_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] ptr_in = '0;
    logic [3:0]  mod_code = '0;
    logic        out_valid, wb_en;
    logic [15:0] addr_out, wb_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    post_mod_agen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ptr_in(ptr_in),
        .mod_code(mod_code), .out_valid(out_valid), .addr_out(addr_out),
        .wb_data(wb_data), .wb_en(wb_en)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] model_nxt(input logic [15:0] p, input logic [3:0] c);
        if (c <= 4'd3)      return p + 16'(c) + 16'd1;
        else if (c <= 4'd7) return p - (16'(c) - 16'd3);
        else                return p;
    endfunction

    // drive at negedge, sample at the following negedge (one register on the way)
    task automatic issue(input string req, input logic [15:0] p, input logic [3:0] c);
        @(negedge clk);
        req_valid = 1'b1; ptr_in = p; mod_code = c;
        @(negedge clk);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " addr"},  32'(addr_out),  32'(p));
        chk({req, " data"},  32'(wb_data),   32'(model_nxt(p, c)));
        chk({req, " wen"},   32'(wb_en),     32'(c <= 4'd7));
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b1; ptr_in = 16'h1234; mod_code = 4'd0;
        repeat (3) @(negedge clk);
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 wen",   32'(wb_en), 0);
        chk("R1 addr",  32'(addr_out), 0);
        chk("R1 data",  32'(wb_data), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after", 32'(out_valid), 0);
    endtask

    task automatic t_up();
        for (int c = 0; c < 4; c++) issue("R4 up", 16'h0100 + 16'(c * 16), 4'(c));
        issue("R3 R4 odd ptr", 16'h2001, 4'd2);
    endtask

    task automatic t_down();
        for (int c = 4; c < 8; c++) issue("R5 down", 16'h0800, 4'(c));
    endtask

    task automatic t_hold();
        for (int c = 8; c < 16; c++) issue("R6 hold", 16'hABCD, 4'(c));
    endtask

    task automatic t_wrap();
        issue("R7 wrap up", 16'hFFFE, 4'd3);
        chk("R7 wrap up value", 32'(wb_data), 32'h0002);
        issue("R7 wrap down", 16'h0001, 4'd7);
        chk("R7 wrap down value", 32'(wb_data), 32'hFFFD);
        issue("R7 edge up", 16'hFFFF, 4'd0);
        issue("R7 edge down", 16'h0000, 4'd4);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0; ptr_in = 16'h5555; mod_code = 4'd1;
        @(negedge clk);
        chk("R2 idle valid", 32'(out_valid), 0);
        chk("R8 idle wen",   32'(wb_en), 0);
        // back-to-back requests
        req_valid = 1'b1; ptr_in = 16'h1000; mod_code = 4'd1;
        @(negedge clk);
        chk("R2 b2b first", 32'(wb_data), 32'h1002);
        ptr_in = 16'h2000; mod_code = 4'd6;
        @(negedge clk);
        chk("R2 b2b second", 32'(wb_data), 32'h1FFD);
        chk("R2 b2b valid", 32'(out_valid), 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 drop valid", 32'(out_valid), 0);
        chk("R8 drop wen", 32'(wb_en), 0);
    endtask

    initial begin
        t_reset();
        t_up();
        t_down();
        t_hold();
        t_wrap();
        t_idle();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule